// File: doc/BRIEF.md
# Read-Protection Level Controller

This block holds the read-protection code of a flash option area and turns it into one of three protection levels: open, read-protected, and chip-protected. From that level, and from two indications (a debugger is attached, or the part booted from RAM), it decides whether each flash read, program or erase attempt goes ahead. A read that is refused raises a bus error.

The block also sequences a commit of a new protection code. Software first opens the option lock by writing two key words in the right order. It then presents the new code and pulses a start strobe. The controller drives one request at a time to an external erase/program engine and advances when that engine returns a done pulse. A commit that lowers the level from read-protected to open first requests a mass erase of the user area. Every other commit only erases the option area and then programs it. Once the chip-protected level is reached, further commits are refused.

The stored code comes from a parameter at reset. It changes only when the final program step of a commit completes.

Top module: `rdp_guard`

## Requirements
- R1: The code 0xAA decodes to level 0 (open) and 0xCC decodes to level 2 (chip-protected). Every other 8-bit code decodes to level 1. `prot_level` carries the level as the unsigned values 0, 1 and 2 and never shows 3.
- R2: After reset, `opt_locked` is 1 and `busy` is 0. All three engine requests are 0. `prot_level` is the level of the INIT_CODE parameter, which is 0xAA (level 0) by default.
- R3: Writing 0x08192A3B and then 0x4C5D6E7F, as two consecutive `key_wr` writes, clears `opt_locked` in the cycle after the second write. Any other first value, or any other second value, keeps the lock set until reset. While the lock is set, `commit_start` has no effect: `busy` stays 0 and no request is raised.
- R4: At level 1 or 2 with `dbg_attached` or `ram_boot` high, `rd_grant` and `pe_grant` are 0 and `bus_err` equals `rd_req`. In every other case `rd_grant` equals `rd_req`, `pe_grant` equals `pe_req`, and `bus_err` is 0. These outputs are combinational.
- R5: A commit from level 1 to a code of level 0 raises `merase_go`, then `oerase_go`, then `oprog_go`. Each request holds until its done pulse is sampled, and at most one request is high in any cycle.
- R6: A commit from level 0 or 1 to any code other than a level-0 code from level 1 raises `oerase_go` and then `oprog_go`, and never raises `merase_go`.
- R7: At level 2, a start pulse while unlocked makes `commit_rej` high for exactly the next cycle. It raises no request, leaves `busy` at 0, and leaves the level at 2.
- R8: `busy` is high from the cycle after an accepted start until the cycle after `oprog_done` is sampled in the program step. While a commit runs, `prot_level` keeps the old level and a further start is ignored. The new level appears together with the fall of `busy`.
- R9: `oprog_code` equals the code presented on `req_code` in the cycle the start was accepted. It stays stable for the whole commit, whatever `req_code` does afterwards.
- R10: A done pulse that does not match the request currently raised has no effect. In particular, done pulses while idle change neither `busy` nor `prot_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_wr | input | 1 | Key register write strobe |
| key_val | input | KEY_W | Key word written |
| opt_locked | output | 1 | Option commit lock (1 = locked) |
| req_code | input | OB_W | Requested protection code |
| commit_start | input | 1 | Start strobe for a commit |
| dbg_attached | input | 1 | Debugger attached indication |
| ram_boot | input | 1 | Boot from RAM indication |
| rd_req | input | 1 | Flash read attempt |
| pe_req | input | 1 | Flash program/erase attempt |
| rd_grant | output | 1 | Read allowed |
| pe_grant | output | 1 | Program/erase allowed |
| bus_err | output | 1 | Refused read returns a bus error |
| prot_level | output | 2 | Current protection level |
| busy | output | 1 | Commit in progress |
| commit_rej | output | 1 | One-cycle pulse when a commit is refused at level 2 |
| merase_go | output | 1 | Mass erase request to the user area |
| merase_done | input | 1 | Mass erase complete pulse |
| oerase_go | output | 1 | Option area erase request |
| oerase_done | input | 1 | Option erase complete pulse |
| oprog_go | output | 1 | Option program request |
| oprog_done | input | 1 | Option program complete pulse |
| oprog_code | output | OB_W | Code to be programmed |

## Verification
The bench sweeps every 8-bit code except the level-2 code through a commit, which covers raises, same-level commits and the single downgrade that needs the mass erase. A design that ordered the steps wrongly, or that erased on a raise, would show a wrong request pattern in some step. During each commit the bench changes `req_code` and pulses start again. A design that took the new code, or that updated the level early, would report the wrong level or the wrong programmed code. The bench also covers the out-of-order key sequence, refusal at the chip level, and stray done pulses while idle. Each of these catches a lock that reopens, a level 2 that can be left, or a sequencer that runs off.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
   typedef enum logic [1:0] {
      LVL_OPEN = 2'd0,
      LVL_READ = 2'd1,
      LVL_CHIP = 2'd2
   } rdp_lvl_e;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_MERASE = 2'd1,
      SQ_OERASE = 2'd2,
      SQ_OPROG  = 2'd3
   } rdp_seq_e;

   typedef enum logic [1:0] {
      KS_WAIT_A = 2'd0,
      KS_WAIT_B = 2'd1,
      KS_OPEN   = 2'd2,
      KS_DEAD   = 2'd3
   } rdp_key_e;
endpackage

// File: rtl/rdp_level_decode.sv
module rdp_level_decode
   import rdp_pkg::*;
#(
   parameter int OB_W = 8,
   parameter logic [OB_W-1:0] OPEN_CODE = 8'hAA,
   parameter logic [OB_W-1:0] CHIP_CODE = 8'hCC
) (
   input  logic [OB_W-1:0] code,
   output rdp_lvl_e        lvl
);
   always_comb begin
      if (code == OPEN_CODE)      lvl = LVL_OPEN;
      else if (code == CHIP_CODE) lvl = LVL_CHIP;
      else                        lvl = LVL_READ;
   end
endmodule

// File: rtl/rdp_key_unlock.sv
module rdp_key_unlock
   import rdp_pkg::*;
#(
   parameter int KEY_W = 32,
   parameter logic [KEY_W-1:0] KEY_A = 32'h08192A3B,
   parameter logic [KEY_W-1:0] KEY_B = 32'h4C5D6E7F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_wr,
   input  logic [KEY_W-1:0] key_val,
   output logic             unlocked
);
   rdp_key_e ks_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ks_q <= KS_WAIT_A;
      end else if (key_wr) begin
         case (ks_q)
            KS_WAIT_A: ks_q <= (key_val == KEY_A) ? KS_WAIT_B : KS_DEAD;
            KS_WAIT_B: ks_q <= (key_val == KEY_B) ? KS_OPEN : KS_DEAD;
            default:   ks_q <= ks_q;
         endcase
      end
   end

   assign unlocked = (ks_q == KS_OPEN);
endmodule

// File: rtl/rdp_commit_seq.sv
module rdp_commit_seq
   import rdp_pkg::*;
#(
   parameter int OB_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            unlocked,
   input  logic            start,
   input  logic [OB_W-1:0] req_code,
   input  rdp_lvl_e        req_lvl,
   input  rdp_lvl_e        cur_lvl,
   input  logic            merase_done,
   input  logic            oerase_done,
   input  logic            oprog_done,
   output logic            merase_go,
   output logic            oerase_go,
   output logic            oprog_go,
   output logic            busy,
   output logic            rej,
   output logic            commit_ok,
   output logic [OB_W-1:0] cap_code
);
   rdp_seq_e st_q;
   logic     take;

   assign take = start && unlocked && (st_q == SQ_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SQ_IDLE;
         rej      <= 1'b0;
         cap_code <= '0;
      end else begin
         rej <= take && (cur_lvl == LVL_CHIP);
         case (st_q)
            SQ_IDLE: begin
               if (take && cur_lvl != LVL_CHIP) begin
                  cap_code <= req_code;
                  st_q <= (cur_lvl == LVL_READ && req_lvl == LVL_OPEN) ? SQ_MERASE : SQ_OERASE;
               end
            end
            SQ_MERASE: if (merase_done) st_q <= SQ_OERASE;
            SQ_OERASE: if (oerase_done) st_q <= SQ_OPROG;
            SQ_OPROG:  if (oprog_done)  st_q <= SQ_IDLE;
            default:   st_q <= SQ_IDLE;
         endcase
      end
   end

   assign merase_go = (st_q == SQ_MERASE);
   assign oerase_go = (st_q == SQ_OERASE);
   assign oprog_go  = (st_q == SQ_OPROG);
   assign busy      = (st_q != SQ_IDLE);
   assign commit_ok = oprog_go && oprog_done;
endmodule

// File: rtl/rdp_guard.sv
module rdp_guard
   import rdp_pkg::*;
#(
   parameter int KEY_W = 32,
   parameter logic [KEY_W-1:0] KEY_A = 32'h08192A3B,
   parameter logic [KEY_W-1:0] KEY_B = 32'h4C5D6E7F,
   parameter int OB_W = 8,
   parameter logic [OB_W-1:0] OPEN_CODE = 8'hAA,
   parameter logic [OB_W-1:0] CHIP_CODE = 8'hCC,
   parameter logic [OB_W-1:0] INIT_CODE = 8'hAA
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_wr,
   input  logic [KEY_W-1:0] key_val,
   output logic             opt_locked,
   input  logic [OB_W-1:0]  req_code,
   input  logic             commit_start,
   input  logic             dbg_attached,
   input  logic             ram_boot,
   input  logic             rd_req,
   input  logic             pe_req,
   output logic             rd_grant,
   output logic             pe_grant,
   output logic             bus_err,
   output logic [1:0]       prot_level,
   output logic             busy,
   output logic             commit_rej,
   output logic             merase_go,
   input  logic             merase_done,
   output logic             oerase_go,
   input  logic             oerase_done,
   output logic             oprog_go,
   input  logic             oprog_done,
   output logic [OB_W-1:0]  oprog_code
);
   localparam int NDEC = 2;

   generate
      if (OPEN_CODE == CHIP_CODE) begin : g_bad_codes
         $error("rdp_guard: OPEN_CODE and CHIP_CODE must differ");
      end
      if (KEY_A == KEY_B) begin : g_bad_keys
         $error("rdp_guard: the two unlock keys must differ");
      end
      if (OB_W < 2) begin : g_bad_width
         $error("rdp_guard: OB_W too small");
      end
   endgenerate

   logic [OB_W-1:0] stored_q;
   logic [OB_W-1:0] dec_in  [NDEC];
   rdp_lvl_e        dec_out [NDEC];
   logic            unlocked, commit_ok, blocked;
   logic [OB_W-1:0] cap_code;

   assign dec_in[0] = stored_q;
   assign dec_in[1] = req_code;

   genvar g;
   generate
      for (g = 0; g < NDEC; g++) begin : g_dec
         rdp_level_decode #(
            .OB_W(OB_W), .OPEN_CODE(OPEN_CODE), .CHIP_CODE(CHIP_CODE)
         ) dec_i (
            .code(dec_in[g]),
            .lvl (dec_out[g])
         );
      end
   endgenerate

   rdp_key_unlock #(.KEY_W(KEY_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) key_i (
      .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_val(key_val), .unlocked(unlocked)
   );

   rdp_commit_seq #(.OB_W(OB_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .unlocked(unlocked), .start(commit_start),
      .req_code(req_code), .req_lvl(dec_out[1]), .cur_lvl(dec_out[0]),
      .merase_done(merase_done), .oerase_done(oerase_done), .oprog_done(oprog_done),
      .merase_go(merase_go), .oerase_go(oerase_go), .oprog_go(oprog_go),
      .busy(busy), .rej(commit_rej), .commit_ok(commit_ok), .cap_code(cap_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         stored_q <= INIT_CODE;
      else if (commit_ok) stored_q <= cap_code;
   end

   assign blocked    = (dec_out[0] != LVL_OPEN) && (dbg_attached || ram_boot);
   assign rd_grant   = rd_req && !blocked;
   assign pe_grant   = pe_req && !blocked;
   assign bus_err    = rd_req && blocked;
   assign prot_level = dec_out[0];
   assign opt_locked = !unlocked;
   assign oprog_code = cap_code;
endmodule

// File: rtl/rdp_guard_chk.sv
module rdp_guard_chk #(
   parameter int OB_W = 8,
   parameter logic [OB_W-1:0] OPEN_CODE = 8'hAA
) (
   input logic            clk,
   input logic            rst_n,
   input logic            opt_locked,
   input logic            dbg_attached,
   input logic            ram_boot,
   input logic            rd_req,
   input logic            pe_req,
   input logic            rd_grant,
   input logic            pe_grant,
   input logic            bus_err,
   input logic [1:0]      prot_level,
   input logic            busy,
   input logic            commit_rej,
   input logic            merase_go,
   input logic            oerase_go,
   input logic            oprog_go,
   input logic            oprog_done,
   input logic [OB_W-1:0] oprog_code
);
   AST_LEVEL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      prot_level != 2'd3); // R1

   AST_LOCKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      opt_locked |-> !busy); // R3

   AST_ACCESS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_level != 2'd0 && (dbg_attached || ram_boot)) |-> (!rd_grant && !pe_grant && bus_err == rd_req)); // R4

   AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({merase_go, oerase_go, oprog_go})); // R5

   AST_MERASE_DOWN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      merase_go |-> (prot_level == 2'd1 && oprog_code == OPEN_CODE)); // R6

   AST_CHIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      prot_level == 2'd2 |=> prot_level == 2'd2); // R7

   AST_REJ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      commit_rej |-> (!busy && prot_level == 2'd2)); // R7

   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !oprog_done) |=> $stable(prot_level)); // R8

   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(merase_go || oerase_go || oprog_go)); // R8

   AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy || $stable(oprog_code))); // R9
endmodule

bind rdp_guard rdp_guard_chk #(.OB_W(OB_W), .OPEN_CODE(OPEN_CODE)) chk_i (
   .clk(clk), .rst_n(rst_n), .opt_locked(opt_locked),
   .dbg_attached(dbg_attached), .ram_boot(ram_boot), .rd_req(rd_req), .pe_req(pe_req),
   .rd_grant(rd_grant), .pe_grant(pe_grant), .bus_err(bus_err),
   .prot_level(prot_level), .busy(busy), .commit_rej(commit_rej),
   .merase_go(merase_go), .oerase_go(oerase_go), .oprog_go(oprog_go),
   .oprog_done(oprog_done), .oprog_code(oprog_code)
);

// File: tb/rdp_guard_tb_top.sv
`timescale 1ns/1ps
module rdp_guard_tb_top;
   localparam logic [31:0] K1 = 32'h08192A3B;
   localparam logic [31:0] K2 = 32'h4C5D6E7F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic key_wr = 1'b0;
   logic [31:0] key_val = '0;
   logic opt_locked;
   logic [7:0] req_code = 8'h00;
   logic commit_start = 1'b0;
   logic dbg_attached = 1'b0, ram_boot = 1'b0, rd_req = 1'b0, pe_req = 1'b0;
   logic rd_grant, pe_grant, bus_err;
   logic [1:0] prot_level;
   logic busy, commit_rej;
   logic merase_go, oerase_go, oprog_go;
   logic merase_done = 1'b0, oerase_done = 1'b0, oprog_done = 1'b0;
   logic [7:0] oprog_code;

   int errors = 0;
   int checks = 0;
   int lvl_model = 0;
   int cycles = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   rdp_guard dut_i (
      .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_val(key_val), .opt_locked(opt_locked),
      .req_code(req_code), .commit_start(commit_start), .dbg_attached(dbg_attached),
      .ram_boot(ram_boot), .rd_req(rd_req), .pe_req(pe_req), .rd_grant(rd_grant),
      .pe_grant(pe_grant), .bus_err(bus_err), .prot_level(prot_level), .busy(busy),
      .commit_rej(commit_rej), .merase_go(merase_go), .merase_done(merase_done),
      .oerase_go(oerase_go), .oerase_done(oerase_done), .oprog_go(oprog_go),
      .oprog_done(oprog_done), .oprog_code(oprog_code)
   );

   function automatic int dec(input logic [7:0] v);
      if (v == 8'hAA) return 0;
      if (v == 8'hCC) return 2;
      return 1;
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !finished) begin
         finished = 1'b1;
         chk(1'b0, "WDOG", "watchdog expired", cycles, 150000);
         summary();
      end
   end

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      lvl_model = 0;
   endtask

   task automatic key(input logic [31:0] v);
      key_wr = 1'b1; key_val = v;
      @(posedge clk); #1 key_wr = 1'b0;
   endtask

   task automatic pulse_start(input logic [7:0] v);
      req_code = v; commit_start = 1'b1;
      @(posedge clk); #1 commit_start = 1'b0;
   endtask

   task automatic access_sweep();
      for (int c = 0; c < 16; c++) begin
         bit blk;
         {dbg_attached, ram_boot, rd_req, pe_req} = c[3:0];
         #1;
         blk = (lvl_model != 0) && (dbg_attached || ram_boot);
         chk(rd_grant == (rd_req && !blk) && pe_grant == (pe_req && !blk) && bus_err == (rd_req && blk),
             "R4", "access gate", {rd_grant, pe_grant, bus_err},
             {rd_req && !blk, pe_req && !blk, rd_req && blk});
      end
      {dbg_attached, ram_boot, rd_req, pe_req} = 4'b0;
   endtask

   task automatic serve(input int which, input logic [7:0] v, input int old, input bit perturb, input string req);
      @(negedge clk);
      chk({oprog_go, oerase_go, merase_go} == 3'(1 << which) && busy && prot_level == 2'(old),
          req, "step request/busy/level", {oprog_go, oerase_go, merase_go, busy, prot_level}, {3'(1 << which), 1'b1, 2'(old)});
      if (which == 2) chk(oprog_code == v, "R9", "programmed code", oprog_code, v);
      @(posedge clk); #1;
      if (perturb) begin commit_start = 1'b1; req_code = ~v; end
      @(posedge clk); #1;
      commit_start = 1'b0;
      case (which)
         0: merase_done = 1'b1;
         1: oerase_done = 1'b1;
         default: oprog_done = 1'b1;
      endcase
      @(posedge clk); #1;
      {merase_done, oerase_done, oprog_done} = 3'b0;
   endtask

   task automatic run_commit(input logic [7:0] v);
      int old = lvl_model;
      bit down = (old == 1) && (dec(v) == 0);
      string r = down ? "R5" : "R6";
      pulse_start(v);
      if (down) serve(0, v, old, 1'b1, r);
      serve(1, v, old, !down, r);
      serve(2, v, old, 1'b0, r);
      @(negedge clk);
      chk(!busy && prot_level == 2'(dec(v)), "R8", "level after commit", {busy, prot_level}, dec(v));
      lvl_model = dec(v);
   endtask

   initial begin
      do_reset();
      @(negedge clk);
      chk(opt_locked == 1'b1, "R2", "lock after reset", opt_locked, 1);
      chk(!busy && !merase_go && !oerase_go && !oprog_go, "R2", "idle after reset",
          {busy, merase_go, oerase_go, oprog_go}, 0);
      chk(prot_level == 2'd0, "R2", "reset level", prot_level, 0);

      pulse_start(8'h00);
      @(negedge clk);
      chk(!busy && !oerase_go && !merase_go, "R3", "start while locked ignored", busy, 0);

      key(K2); key(K1); key(K2);
      @(negedge clk);
      chk(opt_locked == 1'b1, "R3", "wrong order keeps lock", opt_locked, 1);
      pulse_start(8'h00);
      @(negedge clk);
      chk(!busy, "R3", "start ignored after bad key", busy, 0);

      do_reset();
      key(K1); key(32'h4C5D6E7E);
      @(negedge clk);
      chk(opt_locked == 1'b1, "R3", "wrong second key keeps lock", opt_locked, 1);

      do_reset();
      key(K1);
      @(negedge clk);
      chk(opt_locked == 1'b1, "R3", "lock after first key", opt_locked, 1);
      key(K2);
      @(negedge clk);
      chk(opt_locked == 1'b0, "R3", "unlock after key pair", opt_locked, 0);

      access_sweep();

      for (int v = 0; v < 256; v++) begin
         if (v != 8'hCC) run_commit(8'(v));
      end
      chk(prot_level == 2'd1, "R1", "level of code 0xFF", prot_level, 1);
      access_sweep();

      @(posedge clk); #1 oprog_done = 1'b1; oerase_done = 1'b1; merase_done = 1'b1;
      @(posedge clk); #1 {merase_done, oerase_done, oprog_done} = 3'b0;
      @(negedge clk);
      chk(!busy && prot_level == 2'd1 && !oprog_go, "R10", "stray done pulses while idle",
          {busy, prot_level}, 1);

      run_commit(8'hAA);
      run_commit(8'h55);
      run_commit(8'hCC);
      chk(prot_level == 2'd2, "R1", "level of code 0xCC", prot_level, 2);
      access_sweep();

      pulse_start(8'hAA);
      @(negedge clk);
      chk(commit_rej && !busy && !oerase_go && !merase_go, "R7", "commit refused at level 2",
          {commit_rej, busy}, 2'b10);
      @(negedge clk);
      chk(!commit_rej && prot_level == 2'd2, "R7", "level 2 kept", {commit_rej, prot_level}, 2);

      finished = 1'b1;
      summary();
   end
endmodule